// File: doc/BRIEF.md
# Video Memory Data Port

This block is the write side of a tile-based video processor's data port, as seen from the CPU. Each byte written to the port lands at the current video address. The address register then advances by a step that a control register selects. The low 14 bits of the address decide which of three stores receives the byte:

- a pattern RAM holding tile graphics;
- a nametable RAM reached through four remappable 1 KB windows;
- a 32-entry palette in which the four backdrop entries of the upper half fold onto the lower half.

The block keeps two change records that a renderer can acknowledge:

- A bitmap with one dirty bit per 16-byte pattern tile. Any byte written into pattern RAM sets the bit of its tile.
- A flag that rises when a palette write changes a stored colour.

Renderer-side read ports expose each store with one cycle of latency. They are used to observe the stored contents.

Top module: `vdp_data_port`

## Requirements
- R1: On each data write (`data_we`) the address register advances by 32 when bit 2 of the control register is 1, and by 1 when that bit is 0. The other control bits have no effect. The 16-bit address register wraps from 0xFFFF to 0x0000. With neither `data_we` nor `addr_we` asserted, the address holds.
- R2: `addr_we` loads `addr_din` into the address register. When it coincides with a data write, the load wins over the increment, and the byte goes to the address held before the load.
- R3: Decoding uses only address bits [13:0]. For example, a write at 0x4005 stores into pattern byte 0x0005, and a write at 0xFFFF hits palette entry 0x1F.
- R4: A write whose masked address is below 0x2000 stores the byte at that address of the 8 KB pattern RAM. Reading it through `pat_raddr` returns it one cycle later.
- R5: A masked address from 0x2000 to 0x3EFF writes nametable RAM. The physical address is the bank value selected by address bits [11:10], times 1024, plus address bits [9:0]. The range 0x3000–0x3EFF decodes the same way.
- R6: `bank_we` loads `bank_din` (a 2-bit page number) into bank register `bank_sel`. All four bank registers reset to page 0.
- R7: A masked address from 0x3F00 up writes palette entry address[4:0]. When bits [1:0] of that index are 00, bit 4 is cleared, so 0x10/0x14/0x18/0x1C alias 0x00/0x04/0x08/0x0C. Reads through `pal_raddr` apply the same folding.
- R8: A palette entry keeps only bits [5:0] of the written byte.
- R9: A pattern RAM write sets bit address[12:4] of `dirty_map`. Nametable and palette writes leave `dirty_map` unchanged.
- R10: `dirty_clr` clears the whole `dirty_map`. A pattern write in the same cycle still leaves its own tile bit set.
- R11: `pal_changed` rises after a palette write whose 6-bit value differs from the entry's stored value. Writing an equal value leaves it unchanged.
- R12: `pal_chg_clr` clears `pal_changed`, unless a value-changing palette write occurs in the same cycle, in which case the flag ends set.
- R13: After synchronous reset the address is 0, the step is 1, `dirty_map` is all zero, `pal_changed` is 0 and every palette entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Load the control register |
| ctl_din | input | 8 | Control value; bit 2 selects step 32 |
| addr_we | input | 1 | Load the video address register |
| addr_din | input | 16 | New video address |
| bank_we | input | 1 | Load one nametable bank register |
| bank_sel | input | 2 | Which window's bank register to load |
| bank_din | input | 2 | 1 KB page number for that window |
| data_we | input | 1 | Data port write strobe |
| data_din | input | 8 | Data port byte |
| dirty_clr | input | 1 | Acknowledge and clear the tile dirty bitmap |
| pal_chg_clr | input | 1 | Acknowledge and clear the palette-changed flag |
| pat_raddr | input | 13 | Pattern RAM read address |
| nt_raddr | input | 12 | Nametable RAM physical read address |
| pal_raddr | input | 5 | Palette read index (folded like writes) |
| vaddr | output | 16 | Current video address |
| dirty_map | output | 512 | One dirty bit per pattern tile |
| pal_changed | output | 1 | Palette contents changed since last clear |
| pat_rdata | output | 8 | Pattern RAM read data, one cycle after address |
| nt_rdata | output | 8 | Nametable RAM read data, one cycle after address |
| pal_rdata | output | 6 | Palette read data, one cycle after index |

## Verification
Two pairs of functions can fall in the same cycle: a dirty-bit set with a bitmap clear, and a colour-changing palette write with a flag clear. The bench provokes each pair by raising `dirty_clr` or `pal_chg_clr` in the very cycle of the data write. It then judges the outcome at the ports:
- For the bitmap, only the written tile's bit may remain, so `dirty_map` must hold exactly one set bit in the right place.
- For the flag, `pal_changed` must be 1 afterwards and 0 after a clear issued on its own.

A third collision, an address load in the cycle of a data write, is judged by the stored byte position and the resulting `vaddr`.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
  typedef enum logic [1:0] {
    TGT_PAT = 2'd0,
    TGT_NT  = 2'd1,
    TGT_PAL = 2'd2
  } vdp_tgt_e;
endpackage

// File: rtl/vdp_lane_ram.sv
// Byte-wide RAM split into lanes so each lane stays a modest inferred array.
module vdp_lane_ram #(
  parameter int BYTES = 8192,
  parameter int LANES = 2,
  parameter int DW    = 8,
  localparam int AW    = $clog2(BYTES),
  localparam int LB    = $clog2(LANES),
  localparam int DEPTH = BYTES / LANES
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [LB-1:0]    wlane, rlane_q;
  logic [AW-LB-1:0] wword, rword;
  logic [DW-1:0]    rd_lanes [LANES];

  assign wlane = waddr[LB-1:0];
  assign wword = waddr[AW-1:LB];
  assign rword = raddr[AW-1:LB];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (wlane == LB'(g))) mem[wword] <= wdata;
      q <= mem[rword];
    end
    assign rd_lanes[g] = q;
  end

  always_ff @(posedge clk) rlane_q <= raddr[LB-1:0];

  assign rdata = rd_lanes[rlane_q];
endmodule

// File: rtl/vdp_addr_unit.sv
// Video address register, step control and nametable bank registers.
module vdp_addr_unit #(
  parameter int AREG_W    = 16,
  parameter int CTL_W     = 8,
  parameter int STEP_BIT  = 2,
  parameter int WIDE_STEP = 32,
  parameter int WINDOWS   = 4,
  parameter int BANK_W    = 2,
  localparam int WSEL_W   = $clog2(WINDOWS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_we,
  input  logic [CTL_W-1:0]          ctl_din,
  input  logic                      addr_we,
  input  logic [AREG_W-1:0]         addr_din,
  input  logic                      bank_we,
  input  logic [WSEL_W-1:0]         bank_sel,
  input  logic [BANK_W-1:0]         bank_din,
  input  logic                      adv,
  output logic [AREG_W-1:0]         vaddr,
  output logic                      wide,
  output logic [WINDOWS*BANK_W-1:0] banks
);
  logic [AREG_W-1:0] step;

  assign step = wide ? AREG_W'(WIDE_STEP) : AREG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide <= 1'b0;
    end else if (ctl_we) begin
      wide <= ctl_din[STEP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr <= '0;
    end else if (addr_we) begin
      vaddr <= addr_din;
    end else if (adv) begin
      vaddr <= vaddr + step;
    end
  end

  for (genvar w = 0; w < WINDOWS; w++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        banks[w*BANK_W +: BANK_W] <= '0;
      end else if (bank_we && (bank_sel == WSEL_W'(w))) begin
        banks[w*BANK_W +: BANK_W] <= bank_din;
      end
    end
  end
endmodule

// File: rtl/vdp_dirty_map.sv
// One bit per pattern tile; a set in the clearing cycle survives.
module vdp_dirty_map #(
  parameter int TILES = 512,
  localparam int IW   = $clog2(TILES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  input  logic             clr,
  output logic [TILES-1:0] map
);
  always_ff @(posedge clk) begin
    if (rst) begin
      map <= '0;
    end else begin
      if (clr) map <= '0;
      if (set_en) map[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/vdp_palette.sv
// Small palette kept in flops so a write can compare against the old value.
module vdp_palette #(
  parameter int ENTRIES = 32,
  parameter int PW      = 6,
  parameter int DW      = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          chg_clr,
  input  logic [AW-1:0] ridx,
  output logic [PW-1:0] rdata,
  output logic          changed
);
  logic [PW-1:0] ent [ENTRIES];
  logic [AW-1:0] wslot, rslot;
  logic [PW-1:0] wval;
  logic          differs;

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] i);
    logic [AW-1:0] r;
    r = i;
    if (i[1:0] == 2'b00) r[AW-1] = 1'b0;
    return r;
  endfunction

  assign wslot   = fold(widx);
  assign rslot   = fold(ridx);
  assign wval    = wdata[PW-1:0];
  assign differs = ent[wslot] != wval;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (we) begin
      ent[wslot] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      changed <= 1'b0;
      rdata   <= '0;
    end else begin
      rdata <= ent[rslot];
      if (chg_clr) changed <= 1'b0;
      if (we && differs) changed <= 1'b1;
    end
  end
endmodule

// File: rtl/vdp_data_port.sv
// CPU data port: address step, three-way decode, dirty and palette tracking.
module vdp_data_port #(
  parameter int AREG_W       = 16,
  parameter int VA_W         = 14,
  parameter int DW           = 8,
  parameter int CTL_W        = 8,
  parameter int STEP_BIT     = 2,
  parameter int WIDE_STEP    = 32,
  parameter int PAT_BYTES    = 8192,
  parameter int TILE_BYTES   = 16,
  parameter int NT_BYTES     = 4096,
  parameter int NT_WIN_BYTES = 1024,
  parameter int NT_WINDOWS   = 4,
  parameter int PAL_ENTRIES  = 32,
  parameter int PAL_W        = 6,
  parameter int RAM_LANES    = 2,
  parameter logic [VA_W-1:0] NT_BASE  = 14'h2000,
  parameter logic [VA_W-1:0] PAL_BASE = 14'h3F00,
  localparam int PAT_AW  = $clog2(PAT_BYTES),
  localparam int NT_AW   = $clog2(NT_BYTES),
  localparam int WIN_AW  = $clog2(NT_WIN_BYTES),
  localparam int WSEL_W  = $clog2(NT_WINDOWS),
  localparam int BANK_W  = $clog2(NT_BYTES / NT_WIN_BYTES),
  localparam int TILES   = PAT_BYTES / TILE_BYTES,
  localparam int TILE_AW = $clog2(TILES),
  localparam int TB_SH   = $clog2(TILE_BYTES),
  localparam int PAL_AW  = $clog2(PAL_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_din,
  input  logic               addr_we,
  input  logic [AREG_W-1:0]  addr_din,
  input  logic               bank_we,
  input  logic [WSEL_W-1:0]  bank_sel,
  input  logic [BANK_W-1:0]  bank_din,
  input  logic               data_we,
  input  logic [DW-1:0]      data_din,
  input  logic               dirty_clr,
  input  logic               pal_chg_clr,
  input  logic [PAT_AW-1:0]  pat_raddr,
  input  logic [NT_AW-1:0]   nt_raddr,
  input  logic [PAL_AW-1:0]  pal_raddr,
  output logic [AREG_W-1:0]  vaddr,
  output logic [TILES-1:0]   dirty_map,
  output logic               pal_changed,
  output logic [DW-1:0]      pat_rdata,
  output logic [DW-1:0]      nt_rdata,
  output logic [PAL_W-1:0]   pal_rdata
);
  import vdp_pkg::*;

  logic [NT_WINDOWS*BANK_W-1:0] banks;
  logic                         wide_step;
  logic [VA_W-1:0]              va;
  vdp_tgt_e                     tgt;
  logic                         pat_we, nt_we, pal_we;
  logic [WSEL_W-1:0]            win;
  logic [NT_AW-1:0]             nt_waddr;
  logic [TILE_AW-1:0]           tile_idx;

  vdp_addr_unit #(
    .AREG_W(AREG_W), .CTL_W(CTL_W), .STEP_BIT(STEP_BIT),
    .WIDE_STEP(WIDE_STEP), .WINDOWS(NT_WINDOWS), .BANK_W(BANK_W)
  ) u_addr (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_din(ctl_din),
    .addr_we(addr_we), .addr_din(addr_din),
    .bank_we(bank_we), .bank_sel(bank_sel), .bank_din(bank_din),
    .adv(data_we),
    .vaddr(vaddr), .wide(wide_step), .banks(banks)
  );

  // Decode on the address held before this cycle's update.
  assign va = vaddr[VA_W-1:0];

  always_comb begin
    if (va < NT_BASE)       tgt = TGT_PAT;
    else if (va < PAL_BASE) tgt = TGT_NT;
    else                    tgt = TGT_PAL;
  end

  assign pat_we   = data_we && (tgt == TGT_PAT);
  assign nt_we    = data_we && (tgt == TGT_NT);
  assign pal_we   = data_we && (tgt == TGT_PAL);
  assign win      = va[WIN_AW +: WSEL_W];
  assign nt_waddr = {banks[win*BANK_W +: BANK_W], va[WIN_AW-1:0]};
  assign tile_idx = va[TB_SH +: TILE_AW];

  vdp_lane_ram #(.BYTES(PAT_BYTES), .LANES(RAM_LANES), .DW(DW)) u_pat (
    .clk(clk), .we(pat_we), .waddr(va[PAT_AW-1:0]), .wdata(data_din),
    .raddr(pat_raddr), .rdata(pat_rdata)
  );

  vdp_lane_ram #(.BYTES(NT_BYTES), .LANES(RAM_LANES), .DW(DW)) u_nt (
    .clk(clk), .we(nt_we), .waddr(nt_waddr), .wdata(data_din),
    .raddr(nt_raddr), .rdata(nt_rdata)
  );

  vdp_palette #(.ENTRIES(PAL_ENTRIES), .PW(PAL_W), .DW(DW)) u_pal (
    .clk(clk), .rst(rst), .we(pal_we), .widx(va[PAL_AW-1:0]),
    .wdata(data_din), .chg_clr(pal_chg_clr), .ridx(pal_raddr),
    .rdata(pal_rdata), .changed(pal_changed)
  );

  vdp_dirty_map #(.TILES(TILES)) u_dirty (
    .clk(clk), .rst(rst), .set_en(pat_we), .set_idx(tile_idx),
    .clr(dirty_clr), .map(dirty_map)
  );
endmodule

// File: rtl/vdp_data_port_chk.sv
module vdp_data_port_chk #(
  parameter int AREG_W    = 16,
  parameter int WIDE_STEP = 32,
  parameter int TILES     = 512,
  localparam int TILE_AW  = $clog2(TILES)
) (
  input logic               clk,
  input logic               rst,
  input logic               data_we,
  input logic               addr_we,
  input logic [AREG_W-1:0]  addr_din,
  input logic [AREG_W-1:0]  vaddr,
  input logic               wide_step,
  input logic               pat_we,
  input logic               pal_we,
  input logic [TILE_AW-1:0] tile_idx,
  input logic               dirty_clr,
  input logic [TILES-1:0]   dirty_map,
  input logic               pal_chg_clr,
  input logic               pal_changed
);
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    data_we && !addr_we |=> vaddr == $past(vaddr) + ($past(wide_step) ? AREG_W'(WIDE_STEP) : AREG_W'(1))); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_we && !addr_we |=> $stable(vaddr)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> vaddr == $past(addr_din)); // R2
  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
    pat_we |=> dirty_map[$past(tile_idx)]); // R9
  AST_DIRTY_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !pat_we && !dirty_clr |=> $stable(dirty_map)); // R9
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    dirty_clr && !pat_we |=> dirty_map == '0); // R10
  AST_DIRTY_CLEAR_SET: assert property (@(posedge clk) disable iff (rst)
    dirty_clr && pat_we |=> $countones(dirty_map) == 1); // R10
  AST_PALCHG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !pal_we |=> !$rose(pal_changed)); // R11
  AST_PALCHG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pal_chg_clr && !pal_we |=> !pal_changed); // R12
endmodule

bind vdp_data_port vdp_data_port_chk #(
  .AREG_W(AREG_W), .WIDE_STEP(WIDE_STEP), .TILES(TILES)
) u_chk (
  .clk(clk), .rst(rst), .data_we(data_we), .addr_we(addr_we),
  .addr_din(addr_din), .vaddr(vaddr), .wide_step(wide_step),
  .pat_we(pat_we), .pal_we(pal_we), .tile_idx(tile_idx),
  .dirty_clr(dirty_clr), .dirty_map(dirty_map),
  .pal_chg_clr(pal_chg_clr), .pal_changed(pal_changed)
);

// File: tb/vdp_data_port_tb_top.sv
module vdp_data_port_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctl_we = 1'b0;
  logic [7:0]   ctl_din = '0;
  logic         addr_we = 1'b0;
  logic [15:0]  addr_din = '0;
  logic         bank_we = 1'b0;
  logic [1:0]   bank_sel = '0;
  logic [1:0]   bank_din = '0;
  logic         data_we = 1'b0;
  logic [7:0]   data_din = '0;
  logic         dirty_clr = 1'b0;
  logic         pal_chg_clr = 1'b0;
  logic [12:0]  pat_raddr = '0;
  logic [11:0]  nt_raddr = '0;
  logic [4:0]   pal_raddr = '0;
  logic [15:0]  vaddr;
  logic [511:0] dirty_map;
  logic         pal_changed;
  logic [7:0]   pat_rdata;
  logic [7:0]   nt_rdata;
  logic [5:0]   pal_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vdp_data_port dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_din(ctl_din),
    .addr_we(addr_we), .addr_din(addr_din), .bank_we(bank_we),
    .bank_sel(bank_sel), .bank_din(bank_din), .data_we(data_we),
    .data_din(data_din), .dirty_clr(dirty_clr), .pal_chg_clr(pal_chg_clr),
    .pat_raddr(pat_raddr), .nt_raddr(nt_raddr), .pal_raddr(pal_raddr),
    .vaddr(vaddr), .dirty_map(dirty_map), .pal_changed(pal_changed),
    .pat_rdata(pat_rdata), .nt_rdata(nt_rdata), .pal_rdata(pal_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every helper starts and ends at a falling edge.
  task automatic set_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_din = v; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic set_addr(input logic [15:0] a);
    addr_we = 1'b1; addr_din = a; @(negedge clk); addr_we = 1'b0;
  endtask
  task automatic set_bank(input logic [1:0] s, input logic [1:0] v);
    bank_we = 1'b1; bank_sel = s; bank_din = v; @(negedge clk); bank_we = 1'b0;
  endtask
  task automatic wr_ex(input logic [7:0] d, input logic dc, input logic pc);
    data_we = 1'b1; data_din = d; dirty_clr = dc; pal_chg_clr = pc;
    @(negedge clk);
    data_we = 1'b0; dirty_clr = 1'b0; pal_chg_clr = 1'b0;
  endtask
  task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
    set_addr(a); wr_ex(d, 1'b0, 1'b0);
  endtask
  task automatic rd_pat(input logic [12:0] a, output logic [7:0] d);
    pat_raddr = a; @(negedge clk); d = pat_rdata;
  endtask
  task automatic rd_nt(input logic [11:0] a, output logic [7:0] d);
    nt_raddr = a; @(negedge clk); d = nt_rdata;
  endtask
  task automatic rd_pal(input logic [4:0] a, output logic [5:0] d);
    pal_raddr = a; @(negedge clk); d = pal_rdata;
  endtask

  task automatic t_reset();
    logic [5:0] p;
    logic [7:0] n;
    chk("R13 vaddr after reset", vaddr, 32'h0);
    chk("R13 dirty_map after reset", $countones(dirty_map), 0);
    chk("R13 pal_changed after reset", pal_changed, 0);
    rd_pal(5'h05, p);
    chk("R13 palette entry after reset", p, 0);
    // R6: all windows reset to page 0, so 0x2C07 lands at physical 0x007
    wr_at(16'h2C07, 8'h5A);
    rd_nt(12'h007, n);
    chk("R6 reset bank maps window 3 to page 0", n, 8'h5A);
  endtask

  task automatic t_step();
    logic [5:0] p;
    set_addr(16'h0100);
    wr_ex(8'h11, 1'b0, 1'b0);
    chk("R1 default step 1", vaddr, 32'h0101);
    set_ctl(8'h04);
    wr_ex(8'h12, 1'b0, 1'b0);
    chk("R1 step 32 with bit 2 set", vaddr, 32'h0121);
    set_ctl(8'hFB);
    wr_ex(8'h13, 1'b0, 1'b0);
    chk("R1 other control bits ignored", vaddr, 32'h0122);
    @(negedge clk);
    chk("R1 address holds when idle", vaddr, 32'h0122);
    set_addr(16'hFFFF);
    wr_ex(8'h2A, 1'b0, 1'b0);
    chk("R1 wrap at 0xFFFF", vaddr, 32'h0000);
    rd_pal(5'h1F, p);
    chk("R3 0xFFFF hits palette entry 0x1F", p, 6'h2A);
  endtask

  task automatic t_load_collide();
    logic [7:0] d;
    set_addr(16'h0050);
    data_we = 1'b1; data_din = 8'h77; addr_we = 1'b1; addr_din = 16'h1234;
    @(negedge clk);
    data_we = 1'b0; addr_we = 1'b0;
    chk("R2 load wins over increment", vaddr, 32'h1234);
    rd_pat(13'h0050, d);
    chk("R2 byte stored at pre-load address", d, 8'h77);
  endtask

  task automatic t_pattern();
    logic [7:0] d;
    wr_at(16'h1ABC, 8'h3C);
    wr_at(16'h1ABD, 8'hE1);
    rd_pat(13'h1ABC, d);
    chk("R4 pattern even byte", d, 8'h3C);
    rd_pat(13'h1ABD, d);
    chk("R4 pattern odd byte", d, 8'hE1);
    wr_at(16'h4005, 8'hC3);
    chk("R1 vaddr after masked write", vaddr, 32'h4006);
    rd_pat(13'h0005, d);
    chk("R3 0x4005 writes pattern 0x0005", d, 8'hC3);
  endtask

  task automatic t_nametable();
    logic [7:0] d;
    set_bank(2'd0, 2'd3);
    set_bank(2'd1, 2'd1);
    set_bank(2'd2, 2'd2);
    set_bank(2'd3, 2'd0);
    wr_at(16'h2005, 8'hA1);
    wr_at(16'h2BFF, 8'hA2);
    wr_at(16'h3405, 8'hA3);
    wr_at(16'h3EFF, 8'hA4);
    rd_nt(12'hC05, d);
    chk("R5 window 0 to page 3", d, 8'hA1);
    rd_nt(12'hBFF, d);
    chk("R5 window 2 to page 2", d, 8'hA2);
    rd_nt(12'h405, d);
    chk("R5 0x3405 via window 1 to page 1", d, 8'hA3);
    rd_nt(12'h2FF, d);
    chk("R5 0x3EFF via window 3 to page 0", d, 8'hA4);
  endtask

  task automatic t_palette();
    logic [5:0] p;
    wr_at(16'h3F10, 8'hFF);
    rd_pal(5'h00, p);
    chk("R7 0x10 aliases entry 0x00", p, 6'h3F);
    chk("R8 only low 6 bits kept", p, 6'h3F);
    wr_at(16'h3F1C, 8'h15);
    rd_pal(5'h0C, p);
    chk("R7 0x1C aliases entry 0x0C", p, 6'h15);
    wr_at(16'h3F11, 8'h2B);
    rd_pal(5'h01, p);
    chk("R7 0x11 does not alias 0x01", p, 6'h00);
    rd_pal(5'h11, p);
    chk("R7 entry 0x11 holds its value", p, 6'h2B);
    wr_at(16'h3F04, 8'h0E);
    rd_pal(5'h14, p);
    chk("R7 read of 0x14 folds to 0x04", p, 6'h0E);
  endtask

  task automatic t_dirty();
    wr_ex(8'h00, 1'b0, 1'b0); // leaves earlier bits untouched; clear next
    dirty_clr = 1'b1; @(negedge clk); dirty_clr = 1'b0;
    chk("R10 clear empties bitmap", $countones(dirty_map), 0);
    wr_at(16'h0123, 8'h99);
    chk("R9 tile 0x12 set", dirty_map[18], 1);
    chk("R9 only one tile set", $countones(dirty_map), 1);
    wr_at(16'h2100, 8'h01);
    wr_at(16'h3F02, 8'h03);
    chk("R9 nametable and palette writes leave bitmap", $countones(dirty_map), 1);
    set_addr(16'h1FF0);
    wr_ex(8'h44, 1'b1, 1'b0);
    chk("R10 set survives same-cycle clear", dirty_map[511], 1);
    chk("R10 others cleared in that cycle", $countones(dirty_map), 1);
  endtask

  task automatic t_palflag();
    wr_at(16'h3F05, 8'h11);
    pal_chg_clr = 1'b1; @(negedge clk); pal_chg_clr = 1'b0;
    chk("R12 clear drops flag", pal_changed, 0);
    wr_at(16'h3F05, 8'h11);
    chk("R11 same value leaves flag", pal_changed, 0);
    wr_at(16'h3F05, 8'hD1);
    chk("R8 R11 high bits ignored, no change", pal_changed, 0);
    wr_at(16'h3F05, 8'h12);
    chk("R11 changed value raises flag", pal_changed, 1);
    pal_chg_clr = 1'b1; @(negedge clk); pal_chg_clr = 1'b0;
    set_addr(16'h3F05);
    wr_ex(8'h13, 1'b0, 1'b1);
    chk("R12 changing write wins over clear", pal_changed, 1);
    set_addr(16'h3F05);
    wr_ex(8'h13, 1'b0, 1'b1);
    chk("R12 clear with equal-value write", pal_changed, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_step();
    t_load_collide();
    t_pattern();
    t_nametable();
    t_palette();
    t_dirty();
    t_palflag();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule